// File: doc/BRIEF.md
# SDRAM Auto-Refresh Scheduler

This block keeps a four-bank SDRAM refreshed. From a clock-frequency parameter it derives the number of cycles in one refresh slot, which is 15.6 µs rounded down to whole cycles, so that 4096 refreshes fit in each 64 ms window. Every slot that elapses adds one to a backlog of owed refreshes. While the backlog is non-zero, the block asks the main command arbiter for the command bus.

Once the arbiter grants the bus, the block sends the sequence itself. If any bank is open, it first closes all banks and waits the row-precharge time. It then issues the refresh and drives only no-operation until the row-cycle time has passed. A one-cycle done pulse hands the bus back. A self-refresh entry request takes the same path. It is accepted only when the read pipeline reports that its last data has left the bus. The block holds the device in self-refresh until the request drops, then issues the exit command and waits the row-cycle time.

Top module: `sdr_refresh_sched`

## Requirements
- R1: The slot timer expires once every floor(CLK_MHZ × 15.6) cycles after reset, and each expiry raises `pending_o` by one in the following cycle.
- R2: `pending_o` never exceeds PEND_MAX (8). `urgent_o` is high exactly while the backlog equals PEND_MAX.
- R3: When idle, `req_o` rises in the cycle after the backlog becomes non-zero, or after an eligible self-refresh request appears. It stays high through the sequence and is low in the cycle after `done_o`.
- R4: If any bit of `bank_open_i` is set when the grant is seen, the first command is precharge-all (code 1). Refresh (code 2) follows exactly T_RP cycles later, with no-operation (code 0) in between.
- R5: If no bank is open when the grant is seen, refresh (code 2) is the first command, in the cycle after the grant is sampled.
- R6: After refresh, or after self-refresh exit (code 4), `cmd_o` is no-operation for T_RC−1 cycles. `done_o` pulses once, in the last of those cycles.
- R7: A self-refresh request is not acted on while `rd_idle_i` is low. Once accepted, the block issues entry (code 3) after any needed precharge-all and tRP. It then holds `self_o` high, keeps the backlog at zero and pauses the slot timer. Lowering `self_req_i` produces the exit command (code 4) one cycle later.
- R8: `cmd_o` carries a command other than no-operation only while `grant_i` is high.
- R9: Each refresh issued lowers the backlog by one. A slot expiry in the same cycle cancels that decrement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bank_open_i | input | NUM_BANKS | One bit per bank, set while that bank has an active row |
| rd_idle_i | input | 1 | High when the last read data has left the data bus |
| self_req_i | input | 1 | Request to enter and stay in self-refresh |
| grant_i | input | 1 | Arbiter grants the command bus; held while `req_o` is high |
| req_o | output | 1 | Request for the command bus |
| urgent_o | output | 1 | Backlog at its limit; arbiter should give refresh priority |
| cmd_o | output | 3 | Command: 0 no-op, 1 precharge-all, 2 refresh, 3 self-refresh entry, 4 self-refresh exit |
| done_o | output | 1 | One-cycle pulse that ends a sequence |
| self_o | output | 1 | High while the device is held in self-refresh |
| pending_o | output | PEND_W | Number of refreshes owed |

## Verification
The hardest case to reach is a refresh that issues in the same cycle as a slot expiry while the backlog sits at its limit. The count must then stay at eight instead of dropping or wrapping. The bench first withholds the grant for nine slots, which saturates the backlog. It then grants every one of the sixteen open-bank patterns in turn, back to back. Because slots keep expiring during this sweep, refreshes land on expiry cycles, and a per-cycle arithmetic model of the backlog catches any wrong count. Self-refresh is then held for several slot lengths, to show that no backlog builds up while the timer is paused.

// File: rtl/sdr_rfsh_pkg.sv
// Package: shared command and state encodings for the refresh scheduler.
// Assumes: a 3-bit command code that the arbiter decodes to pin levels.
package sdr_rfsh_pkg;

    typedef enum logic [2:0] {
        CMD_NOP  = 3'd0,
        CMD_PALL = 3'd1,
        CMD_REF  = 3'd2,
        CMD_SELF = 3'd3,
        CMD_SRX  = 3'd4
    } rf_cmd_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_REQ,
        S_PRE,
        S_TRP,
        S_REF,
        S_SEN,
        S_SLF,
        S_SEX,
        S_TRC
    } rf_state_e;

    // Cycles per refresh slot: 15.6 us at the given MHz, rounded down.
    function automatic int unsigned slot_cycles(input int unsigned mhz);
        return (mhz * 156) / 10;
    endfunction

endpackage

// File: rtl/rfsh_interval_timer.sv
// Module: down-counter that marks the end of each refresh slot.
// Assumes: RELOAD >= 1; pause_i reloads the counter and suppresses ticks.
module rfsh_interval_timer #(
    parameter int unsigned RELOAD = 2074
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pause_i,
    output logic tick_o
);
    localparam int unsigned CW = (RELOAD > 1) ? $clog2(RELOAD) : 1;
    localparam logic [CW-1:0] LOAD = CW'(RELOAD - 1);

    logic [CW-1:0] cnt_q;

    // Count down each cycle; reload on expiry or while paused.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= LOAD;
        end else if (pause_i || cnt_q == '0) begin
            cnt_q <= LOAD;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Expiry strobe, one cycle per slot.
    always_comb begin
        tick_o = !pause_i && (cnt_q == '0);
    end

endmodule

// File: rtl/rfsh_backlog.sv
// Module: saturating count of refreshes owed.
// Assumes: dec_i is raised only when the count is non-zero; clr_i wins.
module rfsh_backlog #(
    parameter int unsigned PEND_MAX = 8,
    parameter int unsigned PEND_W   = $clog2(PEND_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inc_i,
    input  logic              dec_i,
    input  logic              clr_i,
    output logic [PEND_W-1:0] count_o,
    output logic              full_o
);
    localparam logic [PEND_W-1:0] MAXV = PEND_W'(PEND_MAX);

    logic [PEND_W-1:0] cnt_q;

    // Add on slot expiry, subtract on refresh; both at once leave it unchanged.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            cnt_q <= '0;
        end else if (inc_i && !dec_i && cnt_q != MAXV) begin
            cnt_q <= cnt_q + 1'b1;
        end else if (dec_i && !inc_i && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Present the count and its limit flag.
    always_comb begin
        count_o = cnt_q;
        full_o  = (cnt_q == MAXV);
    end

endmodule

// File: rtl/rfsh_seq_fsm.sv
// Module: sequencer for bus request, precharge-all, refresh and self-refresh.
// Assumes: grant_i is held for as long as req_o is high; T_RP and T_RC >= 2.
module rfsh_seq_fsm
    import sdr_rfsh_pkg::*;
#(
    parameter int unsigned T_RP = 3,
    parameter int unsigned T_RC = 9
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bank_any_i,
    input  logic       rd_idle_i,
    input  logic       self_req_i,
    input  logic       grant_i,
    input  logic       pend_nz_i,
    output logic       req_o,
    output rf_cmd_e    cmd_o,
    output logic       done_o,
    output logic       ref_o,
    output logic       clr_o,
    output logic       pause_o,
    output logic       self_o
);
    localparam int unsigned TMAX = (T_RP > T_RC) ? T_RP : T_RC;
    localparam int unsigned WW   = $clog2(TMAX + 1);
    localparam logic [WW-1:0] RP_LOAD = WW'(T_RP - 1);
    localparam logic [WW-1:0] RC_LOAD = WW'(T_RC - 1);
    localparam logic [WW-1:0] W_ONE   = WW'(1);

    rf_state_e     state_q, state_n;
    logic [WW-1:0] wcnt_q, wcnt_n;
    logic          op_self_q, op_self_n;

    // State, wait counter and the chosen operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= S_IDLE;
            wcnt_q    <= '0;
            op_self_q <= 1'b0;
        end else begin
            state_q   <= state_n;
            wcnt_q    <= wcnt_n;
            op_self_q <= op_self_n;
        end
    end

    // Next state: decide, request, close banks, wait, issue, wait again.
    always_comb begin
        state_n   = state_q;
        wcnt_n    = wcnt_q;
        op_self_n = op_self_q;
        case (state_q)
            S_IDLE: begin
                if (self_req_i && rd_idle_i) begin
                    state_n   = S_REQ;
                    op_self_n = 1'b1;
                end else if (pend_nz_i) begin
                    state_n   = S_REQ;
                    op_self_n = 1'b0;
                end
            end
            S_REQ: begin
                if (grant_i) begin
                    if (bank_any_i)     state_n = S_PRE;
                    else if (op_self_q) state_n = S_SEN;
                    else                state_n = S_REF;
                end
            end
            S_PRE: begin
                state_n = S_TRP;
                wcnt_n  = RP_LOAD;
            end
            S_TRP: begin
                if (wcnt_q == W_ONE) state_n = op_self_q ? S_SEN : S_REF;
                else                 wcnt_n  = wcnt_q - 1'b1;
            end
            S_REF, S_SEX: begin
                state_n = S_TRC;
                wcnt_n  = RC_LOAD;
            end
            S_SEN:   state_n = S_SLF;
            S_SLF:   if (!self_req_i) state_n = S_SEX;
            S_TRC: begin
                if (wcnt_q == W_ONE) state_n = S_IDLE;
                else                 wcnt_n  = wcnt_q - 1'b1;
            end
            default: state_n = S_IDLE;
        endcase
    end

    // Command and strobes decoded from the current state.
    always_comb begin
        case (state_q)
            S_PRE:   cmd_o = CMD_PALL;
            S_REF:   cmd_o = CMD_REF;
            S_SEN:   cmd_o = CMD_SELF;
            S_SEX:   cmd_o = CMD_SRX;
            default: cmd_o = CMD_NOP;
        endcase
        req_o   = (state_q != S_IDLE);
        done_o  = (state_q == S_TRC) && (wcnt_q == W_ONE);
        ref_o   = (state_q == S_REF);
        clr_o   = (state_q == S_SEN);
        pause_o = (state_q == S_SEN) || (state_q == S_SLF);
        self_o  = (state_q == S_SLF);
    end

endmodule

// File: rtl/sdr_refresh_sched.sv
// Module: top of the SDRAM refresh scheduler; joins timer, backlog and sequencer.
// Assumes: the arbiter tracks open banks, honours urgent_o and holds grant_i
// until done_o.
module sdr_refresh_sched
    import sdr_rfsh_pkg::*;
#(
    parameter int unsigned CLK_MHZ   = 133,
    parameter int unsigned NUM_BANKS = 4,
    parameter int unsigned PEND_MAX  = 8,
    parameter int unsigned T_RP      = 3,
    parameter int unsigned T_RC      = 9,
    parameter int unsigned PEND_W    = $clog2(PEND_MAX + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_BANKS-1:0] bank_open_i,
    input  logic                 rd_idle_i,
    input  logic                 self_req_i,
    input  logic                 grant_i,
    output logic                 req_o,
    output logic                 urgent_o,
    output logic [2:0]           cmd_o,
    output logic                 done_o,
    output logic                 self_o,
    output logic [PEND_W-1:0]    pending_o
);
    localparam int unsigned SLOT = slot_cycles(CLK_MHZ);

    logic    tick, ref_iss, clr, pause, bank_any;
    rf_cmd_e cmd;

    // Any open bank forces a precharge-all before the refresh.
    always_comb begin
        bank_any = |bank_open_i;
        cmd_o    = cmd;
    end

    rfsh_interval_timer #(.RELOAD(SLOT)) timer_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .pause_i (pause),
        .tick_o  (tick)
    );

    rfsh_backlog #(.PEND_MAX(PEND_MAX), .PEND_W(PEND_W)) backlog_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc_i   (tick),
        .dec_i   (ref_iss),
        .clr_i   (clr),
        .count_o (pending_o),
        .full_o  (urgent_o)
    );

    rfsh_seq_fsm #(.T_RP(T_RP), .T_RC(T_RC)) seq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .bank_any_i (bank_any),
        .rd_idle_i  (rd_idle_i),
        .self_req_i (self_req_i),
        .grant_i    (grant_i),
        .pend_nz_i  (pending_o != '0),
        .req_o      (req_o),
        .cmd_o      (cmd),
        .done_o     (done_o),
        .ref_o      (ref_iss),
        .clr_o      (clr),
        .pause_o    (pause),
        .self_o     (self_o)
    );

endmodule

// File: rtl/sdr_refresh_sched_chk.sv
// Module: protocol checker bound to the refresh scheduler top.
// Assumes: the command codes of sdr_rfsh_pkg.
module sdr_refresh_sched_chk #(
    parameter int unsigned PEND_MAX = 8,
    parameter int unsigned PEND_W   = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              grant_i,
    input logic              req_o,
    input logic [2:0]        cmd_o,
    input logic              done_o,
    input logic              self_o,
    input logic [PEND_W-1:0] pending_o
);
    assert_cmd_granted_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o != 3'd0) |-> grant_i);

    assert_pend_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pending_o <= PEND_W'(PEND_MAX));

    assert_ref_no_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == 3'd2) |=> (pending_o <= $past(pending_o)));

    assert_nop_after_ref_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == 3'd2) |=> (cmd_o == 3'd0));

    assert_nop_after_pall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == 3'd1) |=> (cmd_o == 3'd0));

    assert_done_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !req_o);

    assert_self_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == 3'd3) |=> (self_o && pending_o == '0));

endmodule

bind sdr_refresh_sched sdr_refresh_sched_chk #(
    .PEND_MAX (PEND_MAX),
    .PEND_W   (PEND_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .grant_i   (grant_i),
    .req_o     (req_o),
    .cmd_o     (cmd_o),
    .done_o    (done_o),
    .self_o    (self_o),
    .pending_o (pending_o)
);

// File: tb/sdr_refresh_sched_tb.sv
// Bench: saturates the backlog, sweeps all open-bank patterns, then exercises
// self-refresh. A per-cycle arithmetic model tracks the backlog.
module sdr_refresh_sched_tb_top;
    localparam int CLK_P   = 10;
    localparam int CLK_MHZ = 1;
    localparam int SLOT    = (CLK_MHZ * 156) / 10;
    localparam int T_RP    = 3;
    localparam int T_RC    = 6;
    localparam int PMAX    = 8;
    localparam int NB      = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NB-1:0] bank_open = '0;
    logic          rd_idle = 1'b1;
    logic          self_req = 1'b0;
    logic          grant = 1'b0;
    logic          req, urgent, done, self_act;
    logic [2:0]    cmd;
    logic [3:0]    pending;

    int checks = 0;
    int errs = 0;
    bit model_en = 1'b0;
    bit finished = 1'b0;

    always #(CLK_P / 2) clk = ~clk;

    sdr_refresh_sched #(
        .CLK_MHZ(CLK_MHZ), .NUM_BANKS(NB), .PEND_MAX(PMAX),
        .T_RP(T_RP), .T_RC(T_RC)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .bank_open_i(bank_open), .rd_idle_i(rd_idle),
        .self_req_i(self_req), .grant_i(grant), .req_o(req), .urgent_o(urgent),
        .cmd_o(cmd), .done_o(done), .self_o(self_act), .pending_o(pending)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Backlog model: slot expiry every SLOT edges, minus one per refresh seen.
    int         m_e = 0;
    int         m_pend = 0;
    logic [2:0] m_prev = 3'd0;
    always @(negedge clk) begin
        if (!rst_n || !model_en) begin
            m_e = 0; m_pend = 0; m_prev = 3'd0;
        end else begin
            automatic bit tk = ((m_e + 1) % SLOT == 0);
            automatic bit dc = (m_prev == 3'd2);
            m_e++;
            if (tk && !dc && m_pend < PMAX) m_pend++;
            else if (dc && !tk && m_pend > 0) m_pend--;
            chk(pending == 4'(m_pend), "R1 R9 backlog", pending, m_pend);
            chk(urgent == (m_pend == PMAX), "R2 urgent", urgent, m_pend == PMAX);
            m_prev = cmd;
        end
    end

    task automatic do_reset();
        rst_n = 1'b0; grant = 1'b0; self_req = 1'b0; rd_idle = 1'b1; bank_open = '0;
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
    endtask

    task automatic wait_req();
        for (int k = 0; k < 200 && !req; k++) @(negedge clk);
    endtask

    // One granted refresh with open-bank pattern p, traced cycle by cycle.
    task automatic refresh_seq(input logic [NB-1:0] p);
        logic [2:0] cs [0:31];
        logic       dn [0:31];
        logic       rq [0:31];
        int tref, last, extra, dcount, rqlow;
        bank_open = p;
        @(negedge clk);
        wait_req();
        grant = 1'b1;
        tref = (p != 0) ? 1 + T_RP : 1;
        last = tref + T_RC;
        for (int j = 1; j <= last; j++) begin
            @(negedge clk);
            cs[j] = cmd; dn[j] = done; rq[j] = req;
            if (cmd == 3'd1) bank_open = '0;
        end
        grant = 1'b0;
        if (p != 0) chk(cs[1] == 3'd1, "R4 first cmd pall", cs[1], 1);
        chk(cs[tref] == 3'd2, (p != 0) ? "R4 ref after trp" : "R5 ref first", cs[tref], 2);
        extra = 0; dcount = 0; rqlow = 0;
        for (int j = 1; j < last; j++) begin
            if (j != tref && !(p != 0 && j == 1) && cs[j] != 3'd0) extra++;
            if (dn[j]) dcount++;
            if (!rq[j]) rqlow++;
        end
        chk(extra == 0, "R6 nop hold", extra, 0);
        chk(dn[last - 1] == 1'b1 && dcount == 1, "R6 done pulse", dcount, 1);
        chk(rqlow == 0, "R3 req held", rqlow, 0);
        chk(rq[last] == 1'b0, "R3 req drop", rq[last], 0);
    endtask

    initial begin
        int bad;
        model_en = 1'b1;
        do_reset();
        @(negedge clk);
        chk(req == 0 && cmd == 0 && pending == 0 && done == 0 && self_act == 0,
            "R3 reset state", {req, cmd, pending}, 0);

        // R1 first slot, R3 request one cycle after backlog appears.
        repeat (SLOT - 1) @(negedge clk);
        chk(pending == 1 && req == 0, "R1 first expiry", pending, 1);
        @(negedge clk);
        chk(req == 1, "R3 req rise", req, 1);

        // R2 saturation after nine slots without a grant.
        repeat (8 * SLOT - 1) @(negedge clk);
        chk(pending == 4'(PMAX) && urgent == 1, "R2 saturate", pending, PMAX);

        // R4 R5 R6 R9 sweep of every open-bank pattern.
        for (int p = 0; p < 16; p++) refresh_seq(4'(p));

        // R7 self-refresh.
        model_en = 1'b0;
        do_reset();
        rd_idle = 1'b0; self_req = 1'b1;
        bad = 0;
        repeat (6) begin @(negedge clk); if (req) bad++; end
        chk(bad == 0, "R7 wait for read idle", bad, 0);
        rd_idle = 1'b1; bank_open = 4'b0010;
        @(negedge clk);
        wait_req();
        grant = 1'b1;
        @(negedge clk);
        chk(cmd == 3'd1, "R7 pall before self", cmd, 1);
        bank_open = '0;
        repeat (T_RP) @(negedge clk);
        chk(cmd == 3'd3, "R7 self entry", cmd, 3);
        bad = 0;
        repeat (3 * SLOT) begin
            @(negedge clk);
            if (!self_act || pending != 0 || cmd != 0 || !req) bad++;
        end
        chk(bad == 0, "R7 held in self refresh", bad, 0);
        self_req = 1'b0;
        @(negedge clk);
        chk(cmd == 3'd4, "R7 self exit", cmd, 4);
        repeat (T_RC - 1) @(negedge clk);
        chk(done == 1, "R6 done after exit", done, 1);
        @(negedge clk);
        chk(req == 0 && self_act == 0, "R3 release after exit", req, 0);
        grant = 1'b0;

        // R8: no command issued without a grant over a long ungranted stretch.
        bad = 0;
        repeat (3 * SLOT) begin @(negedge clk); if (cmd != 0) bad++; end
        chk(bad == 0, "R8 silent without grant", bad, 0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        #(CLK_P * 200000);
        if (!finished) begin
            checks++; errs++;
            $display("FAIL R3 watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

endmodule